// File: doc/BRIEF.md
# Dual Mode Timer/Counter

This block holds two down-counting timer/counter units of parameterized width (16 bits by default) whose roles are assigned together by a single two-bit mode field. Depending on the mode, the pair acts as a free-running pulse-width modulator with separate high and low times, as two free-running time bases that capture their running count on external edges, as two independent timers or external event counters, or as an event counter next to a timer with a capture input. Every counter loads its reload value, steps down once per step, reloads when it steps past zero, and raises a sticky underflow flag at that point.

Software writes a small register port to set the reload values, the mode, the capture edge polarities, the step source of each unit in dual mode, the prescaler divide and the run bit. The same port reads back the configuration, the running counts, the capture registers and the flags. Flags are cleared by writing ones. Time steps come from an internal prescaler that emits one tick every `div + 1` clocks. External steps come from two asynchronous inputs that pass through a multi-stage synchronizer and an edge detector.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, `pwm_o` is 0, all four flag outputs are 0, and the control, reload and capture registers read back as 0.
- R2: Register map (`cfg_addr`): 0 control, 1 reload A, 2 reload B, 3 capture A, 4 capture B, 5 count A, 6 count B, 7 flags. Flags read as {capB, capA, underflowB, underflowA} in bits 3..0. Control fields are bits 1:0 mode, bit 2 run, bit 3 A falling-edge capture, bit 4 B falling-edge capture, bit 5 A external source, bit 6 B external source, and bits 15:8 prescaler divide. Writes to addresses 0 to 2 read back unchanged.
- R3: A unit on the time base with divide D steps once every D+1 clocks, with the first step D+1 clocks after run is set. Starting from reload R, it underflows on step R+1. At that step it reloads R and sets its underflow flag.
- R4: In mode 0 (PWM), after run is set, `pwm_o` is high for RA+1 ticks and then low for RB+1 ticks, repeating, where RA and RB are the two reload values. `pwm_o` is 0 whenever the block is stopped or is in another mode.
- R5: In mode 1 (dual capture), both units count the time base. A selected edge on `ev_a_in` or `ev_b_in` copies unit A's or unit B's running count into the matching capture register and sets the matching capture flag.
- R6: Each capture input uses the rising edge when its polarity bit is 0 and the falling edge when it is 1. The opposite edge captures nothing.
- R7: External inputs pass through two synchronizer flip-flops. Only a rising edge advances an event-driven counter; a falling edge leaves the count unchanged.
- R8: In mode 2 (dual timer), each unit steps on external rising edges of its own input when its source bit is 1, and on the time base when it is 0.
- R9: In mode 3 (mixed), unit A counts rising edges of `ev_a_in`, and unit B counts the time base and captures on the selected edge of `ev_b_in`.
- R10: Edges on the event inputs cause no capture in modes 0 and 2, and no capture on input A in mode 3.
- R11: While run is 0, each counter holds its own reload value, and edges neither count nor capture.
- R12: Writing to address 7 clears exactly the flags whose bits are 1 in the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W | Register write data |
| cfg_rdata | output | CNT_W | Register read data for `cfg_addr` (combinational) |
| ev_a_in | input | 1 | Asynchronous event/capture input for unit A |
| ev_b_in | input | 1 | Asynchronous event/capture input for unit B |
| pwm_o | output | 1 | Pulse-width modulated output |
| uflow_a_o | output | 1 | Sticky underflow flag, unit A |
| uflow_b_o | output | 1 | Sticky underflow flag, unit B |
| cap_a_o | output | 1 | Sticky capture flag, unit A |
| cap_b_o | output | 1 | Sticky capture flag, unit B |

## Verification
The bench checks the underflow flag in the tick just before and the tick exactly at the R+1th step. A counter that reloads on reaching zero, instead of on stepping past it, sets the flag one tick early. The PWM pattern is sampled every cycle over two full periods, so a swapped high/low reload pair or a missing +1 shows up as a shifted or shortened phase. Event counting is read back after the rise and after the fall of each pulse, which catches any counter that also steps on falling edges. Capture inputs are driven in modes that must ignore them, with the wrong polarity, and while the block is stopped. A design that leaks capture strobes across modes would then raise a capture flag that must stay clear.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
   typedef enum logic [1:0] {
      MODE_PWM   = 2'd0,
      MODE_CAP2  = 2'd1,
      MODE_DUAL  = 2'd2,
      MODE_MIXED = 2'd3
   } dmt_mode_e;

   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
   localparam logic [ADDR_W-1:0] A_RLD_A = 3'd1;
   localparam logic [ADDR_W-1:0] A_RLD_B = 3'd2;
   localparam logic [ADDR_W-1:0] A_CAP_A = 3'd3;
   localparam logic [ADDR_W-1:0] A_CAP_B = 3'd4;
   localparam logic [ADDR_W-1:0] A_CNT_A = 3'd5;
   localparam logic [ADDR_W-1:0] A_CNT_B = 3'd6;
   localparam logic [ADDR_W-1:0] A_FLAGS = 3'd7;

   localparam int B_RUN   = 2;
   localparam int B_POL_A = 3;
   localparam int B_POL_B = 4;
   localparam int B_SRC_A = 5;
   localparam int B_SRC_B = 6;
   localparam int DIV_LSB = 8;
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;

   assign tick = run && (pre_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/dmt_edge_sync.sv
module dmt_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[STAGES-1];
   end

   assign rise = sync_q[STAGES-1] & ~prev_q;
   assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dmt_unit.sv
module dmt_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         step,
   input  logic [W-1:0] idle_val,
   input  logic [W-1:0] reload_val,
   input  logic         cap_stb,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cap,
   output logic         uf_p,
   output logic         cap_p
);
   assign uf_p  = run && step && (cnt == '0);
   assign cap_p = run && cap_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= idle_val;
      end else if (step) begin
         if (cnt == '0) cnt <= reload_val;
         else           cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap <= '0;
      end else if (cap_p) begin
         cap <= cnt;
      end
   end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
   import dmt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [CNT_W-1:0]  cfg_wdata,
   output logic [CNT_W-1:0]  cfg_rdata,
   input  logic              ev_a_in,
   input  logic              ev_b_in,
   output logic              pwm_o,
   output logic              uflow_a_o,
   output logic              uflow_b_o,
   output logic              cap_a_o,
   output logic              cap_b_o
);
   localparam int NUNITS = 2;
   localparam int NFLAGS = 2 * NUNITS;

   if (CNT_W < 8) begin : g_bad_width
      $error("dual_mode_timer: CNT_W must be at least 8");
   end
   if (DIV_LSB + PRE_W > CNT_W) begin : g_bad_pre
      $error("dual_mode_timer: prescaler field does not fit the control word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dual_mode_timer: at least two synchronizer stages are required");
   end

   // configuration
   logic [CNT_W-1:0]  ctrl_q;
   logic [CNT_W-1:0]  rld_q [NUNITS];
   logic [NFLAGS-1:0] flags_q;
   logic              pwm_q;

   dmt_mode_e         mode;
   logic              run;
   logic [PRE_W-1:0]  div;
   logic [NUNITS-1:0] pol, src_ext;

   assign mode       = dmt_mode_e'(ctrl_q[1:0]);
   assign run        = ctrl_q[B_RUN];
   assign div        = ctrl_q[DIV_LSB +: PRE_W];
   assign pol[0]     = ctrl_q[B_POL_A];
   assign pol[1]     = ctrl_q[B_POL_B];
   assign src_ext[0] = ctrl_q[B_SRC_A];
   assign src_ext[1] = ctrl_q[B_SRC_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         rld_q[0] <= '0;
         rld_q[1] <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            A_CTRL:  ctrl_q   <= cfg_wdata;
            A_RLD_A: rld_q[0] <= cfg_wdata;
            A_RLD_B: rld_q[1] <= cfg_wdata;
            default: ;
         endcase
      end
   end

   // time base and event inputs
   logic tick;
   logic [NUNITS-1:0] ev_in, ev_rise, ev_fall, ev_sel;

   assign ev_in = {ev_b_in, ev_a_in};

   dmt_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (div),
      .tick (tick)
   );

   for (genvar u = 0; u < NUNITS; u++) begin : g_sync
      dmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (ev_in[u]),
         .rise (ev_rise[u]),
         .fall (ev_fall[u])
      );
      assign ev_sel[u] = pol[u] ? ev_fall[u] : ev_rise[u];
   end

   // role assignment by mode
   logic [NUNITS-1:0] step, cap_stb, uf_p, cap_p;
   logic [CNT_W-1:0]  reload_v [NUNITS];
   logic [CNT_W-1:0]  cnt      [NUNITS];
   logic [CNT_W-1:0]  cap      [NUNITS];

   always_comb begin
      step        = '0;
      cap_stb     = '0;
      reload_v[0] = rld_q[0];
      reload_v[1] = rld_q[1];
      case (mode)
         MODE_PWM: begin
            step[0]     = tick;
            reload_v[0] = pwm_q ? rld_q[1] : rld_q[0];
         end
         MODE_CAP2: begin
            step    = {tick, tick};
            cap_stb = ev_sel;
         end
         MODE_DUAL: begin
            for (int u = 0; u < NUNITS; u++) begin
               step[u] = src_ext[u] ? ev_rise[u] : tick;
            end
         end
         MODE_MIXED: begin
            step[0]    = ev_rise[0];
            step[1]    = tick;
            cap_stb[1] = ev_sel[1];
         end
         default: ;
      endcase
   end

   for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      dmt_unit #(.W(CNT_W)) u_unit (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (run),
         .step      (step[u]),
         .idle_val  (rld_q[u]),
         .reload_val(reload_v[u]),
         .cap_stb   (cap_stb[u]),
         .cnt       (cnt[u]),
         .cap       (cap[u]),
         .uf_p      (uf_p[u]),
         .cap_p     (cap_p[u])
      );
   end

   // PWM phase: high while counting reload A, low while counting reload B
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b1;
      end else if (!run) begin
         pwm_q <= 1'b1;
      end else if (mode == MODE_PWM && uf_p[0]) begin
         pwm_q <= ~pwm_q;
      end
   end

   assign pwm_o = pwm_q && run && (mode == MODE_PWM);

   // sticky flags, write one to clear, a new event wins over a clear
   logic [NFLAGS-1:0] flag_set, flag_clr;

   assign flag_set = {cap_p, uf_p};
   assign flag_clr = (cfg_we && cfg_addr == A_FLAGS) ? cfg_wdata[NFLAGS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~flag_clr) | flag_set;
   end

   assign uflow_a_o = flags_q[0];
   assign uflow_b_o = flags_q[1];
   assign cap_a_o   = flags_q[2];
   assign cap_b_o   = flags_q[3];

   always_comb begin
      case (cfg_addr)
         A_CTRL:  cfg_rdata = ctrl_q;
         A_RLD_A: cfg_rdata = rld_q[0];
         A_RLD_B: cfg_rdata = rld_q[1];
         A_CAP_A: cfg_rdata = cap[0];
         A_CAP_B: cfg_rdata = cap[1];
         A_CNT_A: cfg_rdata = cnt[0];
         A_CNT_B: cfg_rdata = cnt[1];
         default: cfg_rdata = CNT_W'(flags_q);
      endcase
   end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   mode,
   input logic         run,
   input logic         pwm_o,
   input logic [1:0]   step,
   input logic [1:0]   uf_p,
   input logic [1:0]   cap_p,
   input logic [W-1:0] cnt_a,
   input logic [W-1:0] cnt_b,
   input logic [W-1:0] cap_a,
   input logic         uflow_a_o,
   input logic         cap_a_o
);
   // R4: while PWM stays active, the output only changes after an underflow of unit A
   p_pwm_toggle_on_uflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == 2'd0 && $past(run && mode == 2'd0) && !$stable(pwm_o))
      |-> $past(uf_p[0]));

   // R5: the capture register only changes on a capture strobe
   p_cap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cap_p[0]) |-> $stable(cap_a));

   // R3: an underflow flag rises only after an underflow step
   p_uflow_flag_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uflow_a_o) |-> $past(uf_p[0]));

   // R5: a capture flag rises only after a capture strobe
   p_cap_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_a_o) |-> $past(cap_p[0]));

   // R8: a running unit without a step keeps its count
   p_no_step_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step[0]) |=> $stable(cnt_a));

   // R4: unit B is idle during PWM operation
   p_pwm_b_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == 2'd0 && $past(run && mode == 2'd0)) |-> $stable(cnt_b));
endmodule

bind dual_mode_timer dmt_checker #(.W(CNT_W)) u_dmt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (ctrl_q[1:0]),
   .run      (run),
   .pwm_o    (pwm_o),
   .step     (step),
   .uf_p     (uf_p),
   .cap_p    (cap_p),
   .cnt_a    (cnt[0]),
   .cnt_b    (cnt[1]),
   .cap_a    (cap[0]),
   .uflow_a_o(uflow_a_o),
   .cap_a_o  (cap_a_o)
);

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [2:0]   cfg_addr = 3'd0;
   logic [W-1:0] cfg_wdata = '0;
   logic [W-1:0] cfg_rdata;
   logic         ev_a_in = 1'b0;
   logic         ev_b_in = 1'b0;
   logic         pwm_o, uflow_a_o, uflow_b_o, cap_a_o, cap_b_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_mode_timer i_dual_mode_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata),
      .ev_a_in  (ev_a_in),
      .ev_b_in  (ev_b_in),
      .pwm_o    (pwm_o),
      .uflow_a_o(uflow_a_o),
      .uflow_b_o(uflow_b_o),
      .cap_a_o  (cap_a_o),
      .cap_b_o  (cap_b_o)
   );

   // control word fields
   localparam logic [W-1:0] RUN   = 16'h0004;
   localparam logic [W-1:0] POL_A = 16'h0008;
   localparam logic [W-1:0] SRC_A = 16'h0020;

   function automatic logic [W-1:0] ctl(input int mode, input int div);
      return W'(mode) | W'(div << 8);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      cfg_addr = a;
      #1;
      v = int'(cfg_rdata);
   endtask

   task automatic pulse_a();
      @(negedge clk); ev_a_in = 1'b1;
      repeat (5) @(negedge clk);
      ev_a_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse_b();
      @(negedge clk); ev_b_in = 1'b1;
      repeat (5) @(negedge clk);
      ev_b_in = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic stop_and_clear();
      wr(3'd0, '0);
      wr(3'd7, 16'h000F);
   endtask

   task automatic t_reset();
      int v;
      check("R1", "pwm_o", int'(pwm_o), 0);
      check("R1", "flags", int'({cap_b_o, cap_a_o, uflow_b_o, uflow_a_o}), 0);
      rd(3'd0, v); check("R1", "ctrl", v, 0);
      rd(3'd1, v); check("R1", "reload A", v, 0);
      rd(3'd4, v); check("R1", "capture B", v, 0);
   endtask

   task automatic t_regs();
      int v;
      wr(3'd1, 16'h1234);
      wr(3'd2, 16'hBEEF);
      wr(3'd0, 16'h7F78);
      rd(3'd1, v); check("R2", "reload A readback", v, 'h1234);
      rd(3'd2, v); check("R2", "reload B readback", v, 'hBEEF);
      rd(3'd0, v); check("R2", "ctrl readback", v, 'h7F78);
      wr(3'd0, '0);
   endtask

   task automatic t_stopped();
      int v;
      wr(3'd1, 16'd6);
      wr(3'd0, ctl(2, 0) | SRC_A);
      pulse_a();
      rd(3'd5, v); check("R11", "count A while stopped", v, 6);
      check("R11", "underflow A while stopped", int'(uflow_a_o), 0);
      wr(3'd0, ctl(1, 0));
      pulse_a();
      check("R11", "capture flag A while stopped", int'(cap_a_o), 0);
      stop_and_clear();
   endtask

   task automatic t_pwm();
      int highs = 0;
      int errs = 0;
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd4);
      wr(3'd0, ctl(0, 0) | RUN);
      for (int k = 0; k < 16; k++) begin
         logic exp_hi;
         exp_hi = (k % 8) < 3;
         if (pwm_o !== exp_hi) errs++;
         if (pwm_o) highs++;
         @(negedge clk);
      end
      check("R4", "pwm pattern mismatches", errs, 0);
      check("R4", "pwm high cycles in two periods", highs, 6);
      pulse_a();
      check("R10", "capture flag A in PWM mode", int'(cap_a_o), 0);
      stop_and_clear();
      check("R4", "pwm_o after stop", int'(pwm_o), 0);
      wr(3'd0, ctl(1, 0) | RUN);
      check("R4", "pwm_o in capture mode", int'(pwm_o), 0);
      stop_and_clear();
   endtask

   task automatic t_dual();
      int v;
      wr(3'd1, 16'd3);
      wr(3'd2, 16'd4);
      wr(3'd0, ctl(2, 3) | RUN | SRC_A);
      repeat (19) @(negedge clk);
      check("R3", "underflow B one tick early", int'(uflow_b_o), 0);
      @(negedge clk);
      check("R3", "underflow B at step R+1", int'(uflow_b_o), 1);
      rd(3'd6, v); check("R3", "count B reloaded", v, 4);
      rd(3'd5, v); check("R8", "event-sourced A ignores ticks", v, 3);
      ev_a_in = 1'b1;
      repeat (5) @(negedge clk);
      rd(3'd5, v); check("R7", "count A after rising edge", v, 2);
      ev_a_in = 1'b0;
      repeat (5) @(negedge clk);
      rd(3'd5, v); check("R7", "count A after falling edge", v, 2);
      pulse_a(); pulse_a();
      check("R8", "underflow A before 4th event", int'(uflow_a_o), 0);
      pulse_a();
      check("R8", "underflow A on 4th event", int'(uflow_a_o), 1);
      rd(3'd5, v); check("R8", "count A reloaded", v, 3);
      pulse_b();
      check("R10", "capture flag B in dual timer mode", int'(cap_b_o), 0);
      stop_and_clear();
   endtask

   task automatic t_capture();
      int v;
      wr(3'd1, 16'd1000);
      wr(3'd2, 16'd500);
      wr(3'd0, ctl(1, 255) | RUN);
      repeat (637) @(negedge clk);
      check("R5", "capture flag A before edge", int'(cap_a_o), 0);
      ev_a_in = 1'b1; ev_b_in = 1'b1;
      repeat (6) @(negedge clk);
      check("R5", "capture flag A", int'(cap_a_o), 1);
      check("R5", "capture flag B", int'(cap_b_o), 1);
      rd(3'd3, v); check("R5", "capture A value", v, 998);
      rd(3'd4, v); check("R5", "capture B value", v, 498);
      ev_a_in = 1'b0; ev_b_in = 1'b0;
      repeat (6) @(negedge clk);
      stop_and_clear();
      // falling-edge polarity on A
      wr(3'd0, ctl(1, 255) | RUN | POL_A);
      repeat (4) @(negedge clk);
      ev_a_in = 1'b1;
      repeat (6) @(negedge clk);
      check("R6", "rising edge ignored with falling polarity", int'(cap_a_o), 0);
      ev_a_in = 1'b0;
      repeat (6) @(negedge clk);
      check("R6", "falling edge captures", int'(cap_a_o), 1);
      rd(3'd3, v); check("R6", "capture A value on falling edge", v, 1000);
      // selective clear
      wr(3'd7, 16'h0001);
      check("R12", "capture flag A kept", int'(cap_a_o), 1);
      wr(3'd7, 16'h0004);
      check("R12", "capture flag A cleared", int'(cap_a_o), 0);
      stop_and_clear();
   endtask

   task automatic t_mixed();
      int v;
      wr(3'd1, 16'd2);
      wr(3'd2, 16'd700);
      wr(3'd0, ctl(3, 255) | RUN);
      pulse_a(); pulse_a();
      rd(3'd5, v); check("R9", "event count A after two edges", v, 0);
      check("R9", "no underflow A yet", int'(uflow_a_o), 0);
      pulse_a();
      check("R9", "underflow A on third edge", int'(uflow_a_o), 1);
      check("R10", "no capture on A in mixed mode", int'(cap_a_o), 0);
      pulse_b();
      check("R9", "capture flag B in mixed mode", int'(cap_b_o), 1);
      rd(3'd4, v); check("R9", "capture B value in mixed mode", v, 700);
      stop_and_clear();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_stopped();
      t_pwm();
      t_dual();
      t_capture();
      t_mixed();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule